// File: doc/BRIEF.md
# Video Status-Change Interrupt Generator

This block watches nine live status bits from a video decoder front end and turns selected changes of them into one active-high interrupt line. The sources are two active-video flags, a color-kill threshold flag, an ADC over-range flag, a horizontal-lock flag, a nonstandard-video flag, a demodulator-lock flag, a 525-line detect flag and an analog copy-protection flag. Each source has a fixed edge rule:
- Some fire on either edge.
- Some fire only on a rise.
- Horizontal lock fires only on a fall, which is a loss of lock.

The 525-line source is further qualified by the lock flags.

The status bits are brought into the clock domain through a two-flop synchronizer. Each bit's previous sample is kept so that its edges can be seen. A qualified change of an enabled source sets a sticky pending bit. The interrupt line stays high while any pending bit is set. Software reaches the two enable registers and the two pending registers through a small register port. Writes are synchronous and reads are combinational. A read strobe on a pending register clears that register.

Top module: `stat_irq_gen`

## Requirements
- R1: The enable register at address 0x02 holds these enables, with the remaining bit 5 reading 0 and ignoring writes:

  | Bit | Source |
  |-----|--------|
  | 7 | active-video A (`sts_i[0]`) |
  | 6 | active-video B (`sts_i[1]`) |
  | 4 | color kill (`sts_i[2]`) |
  | 3 | ADC over-range (`sts_i[3]`) |
  | 2 | horizontal lock (`sts_i[4]`) |
  | 1 | nonstandard video (`sts_i[5]`) |
  | 0 | demodulator lock (`sts_i[6]`) |

  Writing 0xFF reads back 0xDF.
- R2: The enable register at address 0x03 holds bit 6 for the 525-line source (`sts_i[7]`) and bit 0 for copy protection (`sts_i[8]`). All other bits read 0 and ignore writes, so writing 0xFF reads back 0x41.
- R3: After reset, both enable registers and both pending registers read 0 and `irq_o` is low.
- R4: Active-video A, active-video B and copy protection set their pending bit on any change of their status bit, in either direction.
- R5: Color kill, ADC over-range, nonstandard video and demodulator lock set their pending bit only on a 0-to-1 change. A 1-to-0 change sets nothing.
- R6: Horizontal lock sets its pending bit only on a 1-to-0 change. A 0-to-1 change sets nothing.
- R7: A 525-line status change sets its pending bit only if, in the same sampled cycle, horizontal lock is 1 and demodulator lock is 0.
- R8: A source whose enable bit is 0 sets no pending bit. Clearing an enable bit does not clear a pending bit that is already set.
- R9: The pending bits read at 0x04 (bit layout of 0x02) and at 0x05 (bit layout of 0x03), and they stay set until a read strobe on their address clears them. `irq_o` is high exactly while any pending bit is set. A qualified status change shows on `irq_o` three clock edges after the input changes.
- R10: An event that lands in the same cycle as a clear-on-read of its register is kept. After that cycle the register holds only the new event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sts_i | input | 9 | Live status bits, in the order listed in R1 and R2 |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears the addressed pending register |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Interrupt, high while any pending bit is set |

## Verification
A new qualified status change and a clear-on-read of the same pending register can fall in the same clock cycle. The bench provokes this by first latching one source. It then raises a second source in that register and times a read strobe to land exactly on the edge where the second event reaches the pending flops. The read data must still show only the older bit. A following read must show only the new bit, with the older one gone. Every cycle, `irq_o` and the read data are also compared against a behavioural model.

// File: rtl/stat_irq_gen.sv
module stat_irq_gen #(
  parameter int AW = 8,
  parameter logic [AW-1:0] EN0_ADDR = 8'h02,
  parameter logic [AW-1:0] EN1_ADDR = 8'h03,
  parameter logic [AW-1:0] PND0_ADDR = 8'h04,
  parameter logic [AW-1:0] PND1_ADDR = 8'h05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [8:0]    sts_i,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_we,
  input  logic          reg_rd,
  output logic [7:0]    reg_rdata,
  output logic          irq_o
);

  localparam int VA = 0, VB = 1, CK = 2, AD = 3, HL = 4, NS = 5, DL = 6, LN = 7, CP = 8;
  localparam logic [7:0] EN0_USED = 8'hDF;
  localparam logic [7:0] EN1_USED = 8'h41;

  logic [8:0] s1, s2, sp;
  logic [1:0] fill;
  logic [7:0] en0, en1, pnd0, pnd1;
  logic [8:0] any_e, rise_e, fall_e;
  logic       armed, ln_ok, clr0, clr1;
  logic [7:0] ev0, ev1;

  assign armed  = (fill == 2'd3);
  assign any_e  = s2 ^ sp;
  assign rise_e = s2 & ~sp;
  assign fall_e = ~s2 & sp;
  assign ln_ok  = s2[HL] & ~s2[DL];

  assign ev0 = {8{armed}} & en0 &
               {any_e[VA], any_e[VB], 1'b0, rise_e[CK], rise_e[AD],
                fall_e[HL], rise_e[NS], rise_e[DL]};
  assign ev1 = {8{armed}} & en1 &
               {1'b0, any_e[LN] & ln_ok, 5'b0, any_e[CP]};

  assign clr0 = reg_rd && (reg_addr == PND0_ADDR);
  assign clr1 = reg_rd && (reg_addr == PND1_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      sp   <= '0;
      fill <= '0;
    end else begin
      s1 <= sts_i;
      s2 <= s1;
      sp <= s2;
      if (!armed) fill <= fill + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en0 <= '0;
      en1 <= '0;
    end else if (reg_we) begin
      if (reg_addr == EN0_ADDR) en0 <= reg_wdata & EN0_USED;
      if (reg_addr == EN1_ADDR) en1 <= reg_wdata & EN1_USED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pnd0 <= '0;
      pnd1 <= '0;
    end else begin
      pnd0 <= (clr0 ? 8'h00 : pnd0) | ev0;
      pnd1 <= (clr1 ? 8'h00 : pnd1) | ev1;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == EN0_ADDR)  reg_rdata = en0;
    if (reg_addr == EN1_ADDR)  reg_rdata = en1;
    if (reg_addr == PND0_ADDR) reg_rdata = pnd0;
    if (reg_addr == PND1_ADDR) reg_rdata = pnd1;
  end

  assign irq_o = |{pnd0, pnd1};

  assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr0 |=> ((pnd0 & $past(pnd0)) == $past(pnd0)));

  assert_ckill_fall_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!s2[CK] && sp[CK] && !pnd0[4]) |=> !pnd0[4]);

  assert_hlock_rise_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s2[HL] && !sp[HL] && !pnd0[2]) |=> !pnd0[2]);

  assert_l525_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(s2[HL] && !s2[DL]) && !pnd1[6]) |=> !pnd1[6]);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0[4] && !pnd0[4]) |=> !pnd0[4]);

  assert_event_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && s2[CK] && !sp[CK] && en0[4]) |=> pnd0[4]);

endmodule

// File: tb/tb_stat_irq_gen.sv
module tb_stat_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] sts = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic       we = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stat_irq_gen dut (.clk(clk), .rst_n(rst_n), .sts_i(sts), .reg_addr(addr),
    .reg_wdata(wdata), .reg_we(we), .reg_rd(rd), .reg_rdata(rdata), .irq_o(irq));

  // behavioural reference model
  logic [8:0] hist[$];
  logic [7:0] m_en0, m_en1, m_p0, m_p1;

  function automatic int rule_of(int i); // 0 any, 1 rise, 2 fall
    if (i == 0 || i == 1 || i == 7 || i == 8) return 0;
    if (i == 4) return 2;
    return 1;
  endfunction

  function automatic int reg_of(int i);
    return (i >= 7) ? 1 : 0;
  endfunction

  function automatic int pos_of(int i);
    int p[9] = '{7, 6, 4, 3, 2, 1, 0, 6, 0};
    return p[i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      m_en0 = 0; m_en1 = 0; m_p0 = 0; m_p1 = 0;
    end else begin
      logic [7:0] e0, e1;
      e0 = 0; e1 = 0;
      if (hist.size() >= 3) begin
        logic [8:0] cur, old;
        cur = hist[hist.size()-2];
        old = hist[hist.size()-3];
        for (int i = 0; i < 9; i++) begin
          bit hit;
          case (rule_of(i))
            0: hit = cur[i] != old[i];
            1: hit = cur[i] && !old[i];
            default: hit = !cur[i] && old[i];
          endcase
          if (i == 7 && !(cur[4] && !cur[6])) hit = 0;
          if (hit) begin
            if (reg_of(i) == 0) e0[pos_of(i)] = 1'b1;
            else e1[pos_of(i)] = 1'b1;
          end
        end
      end
      if (rd && addr == 8'h04) m_p0 = 0;
      if (rd && addr == 8'h05) m_p1 = 0;
      m_p0 = m_p0 | (e0 & m_en0);
      m_p1 = m_p1 | (e1 & m_en1);
      if (we && addr == 8'h02) m_en0 = wdata & 8'hDF;
      if (we && addr == 8'h03) m_en1 = wdata & 8'h41;
      hist.push_back(sts);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  function automatic logic [7:0] m_rdata(logic [7:0] a);
    case (a)
      8'h02: return m_en0;
      8'h03: return m_en1;
      8'h04: return m_p0;
      8'h05: return m_p1;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== ((m_p0 | m_p1) != 0)) begin
        errors++;
        $display("FAIL R9 model irq: actual %0b expected %0b", irq, (m_p0 | m_p1) != 0);
      end
      checks++;
      if (rdata !== m_rdata(addr)) begin
        errors++;
        $display("FAIL R9 model rdata @%h: actual %h expected %h", addr, rdata, m_rdata(addr));
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); #1 addr = a; wdata = d; we = 1'b1;
    @(negedge clk); #1 we = 1'b0;
  endtask

  task automatic rdchk(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); #1 addr = a; rd = 1'b1;
    #1 chk(tag, rdata, exp);
    @(negedge clk); #1 rd = 1'b0;
  endtask

  task automatic setb(int i, logic v);
    @(negedge clk); #1 sts[i] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R3 irq after reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    rdchk(8'h02, 8'h00, "R3 enable0 reset");
    rdchk(8'h03, 8'h00, "R3 enable1 reset");
    rdchk(8'h04, 8'h00, "R3 pending0 reset");
    rdchk(8'h05, 8'h00, "R3 pending1 reset");
    repeat (4) @(negedge clk);

    wr(8'h02, 8'hFF); rdchk(8'h02, 8'hDF, "R1 enable0 reserved bit");
    wr(8'h03, 8'hFF); rdchk(8'h03, 8'h41, "R2 enable1 reserved bits");

    setb(2, 1);
    chk("R9 irq after rise", {7'b0, irq}, 8'h01);
    rdchk(8'h04, 8'h10, "R5 color kill rise");
    #1 chk("R9 irq after clear", {7'b0, irq}, 8'h00);
    rdchk(8'h04, 8'h00, "R9 pending0 cleared");
    setb(2, 0); rdchk(8'h04, 8'h00, "R5 color kill fall silent");

    setb(0, 1); rdchk(8'h04, 8'h80, "R4 video A rise");
    setb(0, 0); rdchk(8'h04, 8'h80, "R4 video A fall");
    setb(1, 1); rdchk(8'h04, 8'h40, "R4 video B rise");

    setb(4, 1); rdchk(8'h04, 8'h00, "R6 hlock rise silent");
    setb(4, 0); rdchk(8'h04, 8'h04, "R6 hlock loss");

    setb(7, 1); rdchk(8'h05, 8'h00, "R7 l525 without hlock");
    setb(4, 1); setb(7, 0); rdchk(8'h05, 8'h40, "R7 l525 gated open");
    setb(6, 1); rdchk(8'h04, 8'h01, "R5 demod lock rise");
    setb(7, 1); rdchk(8'h05, 8'h00, "R7 l525 with demod lock");

    setb(8, 1); rdchk(8'h05, 8'h01, "R4 copy protect rise");
    setb(8, 0); rdchk(8'h05, 8'h01, "R4 copy protect fall");

    wr(8'h02, 8'h00);
    setb(3, 1); rdchk(8'h04, 8'h00, "R8 masked adc");
    setb(3, 0);
    wr(8'h02, 8'h08);
    setb(3, 1); wr(8'h02, 8'h00);
    chk("R8 irq held after unmask", {7'b0, irq}, 8'h01);
    rdchk(8'h04, 8'h08, "R8 pending kept");

    wr(8'h02, 8'hFF);
    setb(5, 1);
    @(negedge clk); #1 sts[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); #1 addr = 8'h04; rd = 1'b1;
    #1 chk("R10 read before collision", rdata, 8'h02);
    @(negedge clk); #1 rd = 1'b0;
    rdchk(8'h04, 8'h10, "R10 event survives clear");
    #1 chk("R9 irq idle at end", {7'b0, irq}, 8'h00);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule